// File: doc/BRIEF.md
# I2C Block-Write Configuration Target

This block is a standard-mode I2C target that lets a bus controller program a small bank of byte-wide configuration registers in a clock-distribution device. A transaction opens with the target's 7-bit address and a write direction bit. A command byte follows; it is acknowledged and its value is discarded. Next comes a byte-count byte, and then the payload. Payload bytes fill the registers from index 0 upward, one per byte.

SCL and SDA arrive as plain inputs and are oversampled on the system clock. The only bus output is an open-drain pull-down enable for SDA, which is asserted only in acknowledge slots. The register bank appears as one flat parallel output bus. A power-down input makes the block ignore the bus completely while it keeps every register value. SCL is never driven, so the controller sets the pace of every transfer.

Top module: `cfg_i2c_blkwr`

## Requirements
- R1: The address byte is acknowledged only when its upper seven bits equal the parameter `TGT_ADDR` and its least significant bit (direction) is 0. A read request, any other address and the all-zero general-call address all get no acknowledge, and the rest of that transaction has no effect.
- R2: The byte after the address (command) is always acknowledged, and its value has no influence on which registers are written.
- R3: A byte count of 0, or one above 32, is not acknowledged. The transaction is then dropped and no register changes.
- R4: A byte count N (1..32) causes data byte k (k = 0..N-1) to be written to register k, in order. Registers not addressed keep their values.
- R5: No register changes before the acknowledge slot of the byte-count byte has completed. A transaction that ends before that point leaves every register unchanged.
- R6: Data bytes past the byte count are not acknowledged and are discarded. Bytes within the count whose index is NREG or higher are acknowledged and discarded. Neither case alters any register.
- R7: A START (SDA falling while SCL high) or STOP (SDA rising while SCL high) at any point ends the current block. Bytes already written stay, and a repeated START begins a fresh address phase.
- R8: While `pdn` is 1, bus activity is ignored, `sda_oe` is 0 and all register values are held. After `pdn` returns to 0, a new transaction works normally.
- R9: `sda_oe` becomes active only while the synchronised SCL is low, and only for an acknowledge slot. The block has no output on SCL.
- R10: After reset every register reads 0 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| pdn | input | 1 | Power-down: ignore bus, keep registers |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| cfg_out | output | NREG*8 | Register k on bits [8k+7:8k] |

## Verification
The bound checker tests, on every cycle, the invariants that do not depend on message content. It checks that the acknowledge drive starts only with SCL low. It checks that register writes happen only in the payload phase and with an index inside the bank. It also checks that power-down releases SDA and freezes the registers. Whether the right address, count and payload bytes produce the right acknowledges and register values can only be shown by the bench's scenarios. The bench covers matching and non-matching addresses, illegal counts, surplus bytes, early aborts, repeated START and power-down, and compares the acknowledges and register contents against its own model.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_ADDR,
    PS_CMD,
    PS_CNT,
    PS_DATA,
    PS_SKIP
  } pstate_t;

  localparam int unsigned MAX_COUNT = 32;
  localparam int unsigned CNT_W     = $clog2(MAX_COUNT + 1);
endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic            scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC-2:0], sda_in};
      scl_d  <= scl_sh[SYNC-1];
      sda_d  <= sda_sh[SYNC-1];
    end
  end

  assign scl_s     = scl_sh[SYNC-1];
  assign sda_s     = sda_sh[SYNC-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_blk_parser.sv
module i2c_blk_parser
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h69,
  parameter int         NREG     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pdn,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             we,
  output logic [CNT_W-1:0] widx,
  output logic [7:0]       wdata,
  output pstate_t          st
);
  logic [7:0]       sh;
  logic [3:0]       bit_cnt;
  logic             in_ack;
  logic             ack_ok;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] idx;

  always_comb begin
    unique case (st)
      PS_ADDR: ack_ok = (sh[7:1] == TGT_ADDR) && !sh[0];
      PS_CMD:  ack_ok = 1'b1;
      PS_CNT:  ack_ok = (sh != 8'd0) && (sh <= 8'(MAX_COUNT));
      PS_DATA: ack_ok = (remain != '0);
      default: ack_ok = 1'b0;
    endcase
  end

  // commit happens as the acknowledge slot of a payload byte ends
  assign we    = !pdn && !start_det && !stop_det && in_ack && scl_fall
              && sda_oe && (st == PS_DATA) && (idx < CNT_W'(NREG));
  assign widx  = idx;
  assign wdata = sh;

  always_ff @(posedge clk) begin
    if (rst || pdn) begin
      st      <= PS_IDLE;
      sda_oe  <= 1'b0;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      remain  <= '0;
      idx     <= '0;
      sh      <= '0;
    end else if (start_det || stop_det) begin
      st      <= start_det ? PS_ADDR : PS_IDLE;
      sda_oe  <= 1'b0;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
    end else if (st != PS_IDLE && st != PS_SKIP) begin
      if (scl_rise && !in_ack && bit_cnt != 4'd8) begin
        sh      <= {sh[6:0], sda_s};
        bit_cnt <= bit_cnt + 4'd1;
      end else if (scl_fall && !in_ack && bit_cnt == 4'd8) begin
        in_ack <= 1'b1;
        sda_oe <= ack_ok;
      end else if (scl_fall && in_ack) begin
        in_ack  <= 1'b0;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        if (!sda_oe) begin
          st <= PS_SKIP;
        end else begin
          unique case (st)
            PS_ADDR: st <= PS_CMD;
            PS_CMD:  st <= PS_CNT;
            PS_CNT: begin
              remain <= sh[CNT_W-1:0];
              idx    <= '0;
              st     <= PS_DATA;
            end
            PS_DATA: begin
              remain <= remain - 1'b1;
              idx    <= idx + 1'b1;
            end
            default: st <= PS_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import i2c_cfg_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CNT_W-1:0]  widx,
  input  logic [7:0]        wdata,
  output logic [NREG*8-1:0] cfg_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] r;
    always_ff @(posedge clk) begin
      if (rst)                             r <= '0;
      else if (we && widx == CNT_W'(g))    r <= wdata;
    end
    assign cfg_flat[g*8 +: 8] = r;
  end
endmodule

// File: rtl/cfg_i2c_blkwr.sv
module cfg_i2c_blkwr
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h69,
  parameter int         NREG     = 8,
  parameter int         SYNC     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_out
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             we;
  logic [CNT_W-1:0] widx;
  logic [7:0]       wdata;
  pstate_t          st;

  i2c_bus_sense #(.SYNC(SYNC)) u_sense (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_blk_parser #(.TGT_ADDR(TGT_ADDR), .NREG(NREG)) u_parse (
    .clk(clk), .rst(rst), .pdn(pdn), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .we(we), .widx(widx), .wdata(wdata), .st(st)
  );

  cfg_reg_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .we(we), .widx(widx), .wdata(wdata),
    .cfg_flat(cfg_out)
  );
endmodule

// File: rtl/cfg_i2c_blkwr_chk.sv
module cfg_i2c_blkwr_chk
  import i2c_cfg_pkg::*;
#(
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pdn,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              we,
  input logic [CNT_W-1:0]  widx,
  input pstate_t           st,
  input logic [NREG*8-1:0] cfg_out
);
  p_pdn_hold_r8: assert property (@(posedge clk) disable iff (rst)
    pdn |=> $stable(cfg_out));

  p_pdn_release_r8: assert property (@(posedge clk) disable iff (rst)
    pdn |=> !sda_oe);

  p_ack_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  p_commit_in_data_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_out) |-> $past(st) == PS_DATA);

  p_index_in_bank_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> widx < CNT_W'(NREG));
endmodule

bind cfg_i2c_blkwr cfg_i2c_blkwr_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .pdn(pdn), .scl_s(scl_s), .sda_oe(sda_oe),
  .we(we), .widx(widx), .st(st), .cfg_out(cfg_out)
);

// File: tb/test_cfg_i2c_blkwr.sv
module test_cfg_i2c_blkwr;
  localparam int         NREG = 8;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int         Q    = 10;
  localparam logic [7:0] WR   = {ADDR, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdn = 1'b0;
  logic tb_scl = 1'b1, tb_sda = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_out;
  wire  sda_line = tb_sda & ~sda_oe;

  int checks = 0, errors = 0, r9_viol = 0;
  logic [7:0] model [NREG];
  logic ack;

  always #5 clk = ~clk;

  cfg_i2c_blkwr #(.TGT_ADDR(ADDR), .NREG(NREG)) i_cfg_i2c_blkwr (
    .clk(clk), .rst(rst), .pdn(pdn), .scl_in(tb_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .cfg_out(cfg_out)
  );

  // R9: acknowledge drive must never start while the bus clock is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (sda_oe && !oe_prev && tb_scl) r9_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    tb_sda = 1'b1; wq(); tb_scl = 1'b1; wq();
    tb_sda = 1'b0; wq(); tb_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    tb_sda = 1'b0; wq(); tb_scl = 1'b1; wq(); tb_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      repeat (2) @(negedge clk);
      tb_sda = b[i]; wq(); tb_scl = 1'b1; wq(); tb_scl = 1'b0;
    end
    repeat (2) @(negedge clk);
    tb_sda = 1'b1; wq(); tb_scl = 1'b1;
    repeat (Q/2) @(negedge clk);
    a = ~sda_line;
    repeat (Q/2) @(negedge clk);
    tb_scl = 1'b0;
  endtask

  task automatic cmp_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(cfg_out[i*8 +: 8] == model[i], req, cfg_out[i*8 +: 8], model[i]);
  endtask

  task automatic t_reset();
    chk(cfg_out == '0, "R10", 32'(cfg_out), 0);
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);
  endtask

  task automatic t_basic();
    bus_start();
    send_byte(WR, ack);    chk(ack, "R1", ack, 1);
    send_byte(8'h00, ack); chk(ack, "R2", ack, 1);
    send_byte(8'd3, ack);  chk(ack, "R4", ack, 1);
    send_byte(8'hA1, ack); chk(ack, "R4", ack, 1);
    send_byte(8'hB2, ack); chk(ack, "R4", ack, 1);
    send_byte(8'hC3, ack); chk(ack, "R4", ack, 1);
    bus_stop();
    model[0] = 8'hA1; model[1] = 8'hB2; model[2] = 8'hC3;
    cmp_regs("R4");
    chk(sda_oe == 1'b0, "R9", sda_oe, 0);
  endtask

  task automatic t_addr();
    bus_start(); send_byte({ADDR, 1'b1}, ack); chk(!ack, "R1 read", ack, 0);
    send_byte(8'h00, ack); send_byte(8'd1, ack); send_byte(8'h99, ack); bus_stop();
    bus_start(); send_byte(8'h44, ack); chk(!ack, "R1 other", ack, 0);
    send_byte(8'h00, ack); send_byte(8'd1, ack); send_byte(8'h98, ack); bus_stop();
    bus_start(); send_byte(8'h00, ack); chk(!ack, "R1 gcall", ack, 0); bus_stop();
    cmp_regs("R1");
  endtask

  task automatic t_count();
    bus_start(); send_byte(WR, ack); send_byte(8'h00, ack);
    send_byte(8'd0, ack);  chk(!ack, "R3 zero", ack, 0);
    send_byte(8'h55, ack); chk(!ack, "R3 after zero", ack, 0);
    bus_stop();
    bus_start(); send_byte(WR, ack); send_byte(8'h00, ack);
    send_byte(8'd33, ack); chk(!ack, "R3 33", ack, 0);
    send_byte(8'h56, ack); bus_stop();
    cmp_regs("R3");
  endtask

  task automatic t_early_and_cmd();
    bus_start(); send_byte(WR, ack); send_byte(8'h00, ack); bus_stop();
    cmp_regs("R5");
    bus_start(); send_byte(WR, ack); send_byte(8'hFF, ack);
    chk(ack, "R2 cmd ff", ack, 1);
    send_byte(8'd1, ack); send_byte(8'h11, ack); bus_stop();
    model[0] = 8'h11;
    cmp_regs("R2");
  endtask

  task automatic t_excess();
    bus_start(); send_byte(WR, ack); send_byte(8'h00, ack); send_byte(8'd2, ack);
    send_byte(8'h21, ack); send_byte(8'h22, ack);
    send_byte(8'h23, ack); chk(!ack, "R6 past count", ack, 0);
    bus_stop();
    model[0] = 8'h21; model[1] = 8'h22;
    cmp_regs("R6");
    bus_start(); send_byte(WR, ack); send_byte(8'h00, ack); send_byte(8'd10, ack);
    for (int i = 0; i < 10; i++) begin
      send_byte(8'h30 + 8'(i), ack);
      chk(ack, "R6 within count", ack, 1);
    end
    bus_stop();
    for (int i = 0; i < NREG; i++) model[i] = 8'h30 + 8'(i);
    cmp_regs("R6");
  endtask

  task automatic t_abort();
    bus_start(); send_byte(WR, ack); send_byte(8'h00, ack); send_byte(8'd5, ack);
    send_byte(8'h40, ack); send_byte(8'h41, ack);
    bus_start();
    send_byte(WR, ack); chk(ack, "R7 restart addr", ack, 1);
    send_byte(8'h00, ack); send_byte(8'd1, ack); send_byte(8'h50, ack);
    bus_stop();
    model[0] = 8'h50; model[1] = 8'h41;
    cmp_regs("R7");
  endtask

  task automatic t_pdn();
    pdn = 1'b1; wq();
    bus_start(); send_byte(WR, ack); chk(!ack, "R8 ignored", ack, 0);
    send_byte(8'h00, ack); send_byte(8'd1, ack); send_byte(8'h77, ack); bus_stop();
    chk(sda_oe == 1'b0, "R8", sda_oe, 0);
    cmp_regs("R8");
    pdn = 1'b0; wq();
    bus_start(); send_byte(WR, ack); chk(ack, "R8 resume", ack, 1);
    send_byte(8'h00, ack); send_byte(8'd1, ack); send_byte(8'h78, ack); bus_stop();
    model[0] = 8'h78;
    cmp_regs("R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_addr();
    t_count();
    t_early_and_cmd();
    t_excess();
    t_abort();
    t_pdn();
    chk(r9_viol == 0, "R9", r9_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule